// File: doc/BRIEF.md
# Auto-restart and fault sequencer

This block is the supervisory state machine of a self-biased switching controller. Its inputs are synchronous flags from comparators that watch the controller's own supply: supply above the upper threshold, supply below the lower threshold, and supply below the power-up reset level. A fourth input reports over-temperature. Its two control outputs enable the start-up charging current source and enable power switching.

At first power-up the block charges the supply and starts switching as soon as the supply first reaches the upper threshold. If the supply later sags to the lower threshold, switching stops. The supply is then held between the two thresholds by toggling the current source. Switching is allowed to resume only once every 2**CNT_W charge/discharge cycles, which is every eighth cycle by default. An over-temperature event latches switching off while the supply keeps cycling. Only a drop of the supply below the power-up reset level clears that latch. The state code and the restart counter are brought out for observation.

Top module: `restart_seq`

## Requirements
- R1: During and right after reset, `mode` is START (code 0), `src_en` is 1, `sw_en` is 0 and `rst_cnt` is 0.
- R2: In START, a rising edge of `vc_hi` moves the block to RUN (code 1) on the next clock edge, with `src_en` 0 and `sw_en` 1.
- R3: In RUN, `vc_lo` moves the block to AUTO (code 2) on the next edge, with `sw_en` 0, `src_en` 1 and `rst_cnt` 0.
- R4: In AUTO and LATCH (code 3), `vc_lo` sets `src_en` to 1 and a rising edge of `vc_hi` clears it to 0, while `sw_en` stays 0.
- R5: In AUTO, each rising edge of `vc_hi` that comes while `src_en` is 1 completes one cycle and adds one to the CNT_W-bit `rst_cnt`.
- R6: The completion that finds `rst_cnt` at 2**CNT_W-1 (7 by default) returns the block to RUN with `rst_cnt` 0, `src_en` 0 and `sw_en` 1.
- R7: `hot` in START, RUN or AUTO moves the block to LATCH with `sw_en` 0 and `rst_cnt` 0. LATCH is left only through `vc_por`, and `rst_cnt` does not count while the block is latched.
- R8: `vc_por` outranks every other input. On the next edge it forces START with `src_en` 1 and `rst_cnt` 0, and the next rising edge of `vc_hi` starts switching at once.
- R9: `src_en` and `sw_en` are never 1 together.
- R10: When `hot` falls in the same cycle as the restart-releasing completion of R6, LATCH wins and `sw_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vc_hi | input | 1 | Supply at or above upper threshold |
| vc_lo | input | 1 | Supply at or below lower threshold |
| vc_por | input | 1 | Supply below power-up reset level |
| hot | input | 1 | Over-temperature flag |
| src_en | output | 1 | Start-up current source enable |
| sw_en | output | 1 | Power switching enable |
| mode | output | 2 | State code: 0 START, 1 RUN, 2 AUTO, 3 LATCH |
| rst_cnt | output | CNT_W | Completed restart cycles in AUTO |

## Verification
Two pairs of functions can act in one cycle. The first pair is a thermal event and the eighth restart completion. The bench raises `hot` in the same cycle as the eighth rising edge of `vc_hi` in AUTO, and it expects LATCH with switching off, not a return to RUN. The second pair is a power-up reset and a thermal event. The bench drives `vc_por` and `hot` together and expects START with a cleared counter. It then confirms that the next rising edge of `vc_hi` starts switching without a new count.

// File: rtl/restart_seq.sv
module restart_seq #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vc_hi,
  input  logic             vc_lo,
  input  logic             vc_por,
  input  logic             hot,
  output logic             src_en,
  output logic             sw_en,
  output logic [1:0]       mode,
  output logic [CNT_W-1:0] rst_cnt
);
  localparam logic [1:0] M_START = 2'd0;
  localparam logic [1:0] M_RUN   = 2'd1;
  localparam logic [1:0] M_AUTO  = 2'd2;
  localparam logic [1:0] M_LATCH = 2'd3;
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic hi_q;
  logic hi_rise;

  assign hi_rise = vc_hi & ~hi_q;
  assign sw_en   = (mode == M_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_START;
      src_en  <= 1'b1;
      rst_cnt <= '0;
      hi_q    <= 1'b0;
    end else begin
      hi_q <= vc_hi;
      if (vc_por) begin
        mode    <= M_START;
        src_en  <= 1'b1;
        rst_cnt <= '0;
      end else if (hot && mode != M_LATCH) begin
        mode    <= M_LATCH;
        src_en  <= 1'b0;
        rst_cnt <= '0;
      end else begin
        case (mode)
          M_START: if (hi_rise) begin
            mode   <= M_RUN;
            src_en <= 1'b0;
          end
          M_RUN: if (vc_lo) begin
            mode    <= M_AUTO;
            src_en  <= 1'b1;
            rst_cnt <= '0;
          end
          M_AUTO: begin
            if (vc_lo) src_en <= 1'b1;
            else if (hi_rise && src_en) begin
              src_en <= 1'b0;
              if (rst_cnt == CNT_LAST) begin
                mode    <= M_RUN;
                rst_cnt <= '0;
              end else begin
                rst_cnt <= rst_cnt + 1'b1;
              end
            end
          end
          default: begin
            if (vc_lo) src_en <= 1'b1;
            else if (hi_rise) src_en <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

module restart_seq_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vc_lo,
  input logic             vc_por,
  input logic             hot,
  input logic             src_en,
  input logic             sw_en,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] rst_cnt
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_en && sw_en));

  p_run_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && vc_lo && !vc_por && !hot) |=> (mode == 2'd2 && src_en && rst_cnt == '0));

  p_por_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vc_por |=> (mode == 2'd0 && src_en && rst_cnt == '0));

  p_hot_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hot && !vc_por) |=> (mode == 2'd3 && !sw_en));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !vc_por) |=> (mode == 2'd3 && rst_cnt == '0));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !vc_por && !hot) |=>
      (rst_cnt == $past(rst_cnt) || rst_cnt == $past(rst_cnt) + 1'b1 || rst_cnt == '0));
endmodule

bind restart_seq restart_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vc_lo(vc_lo), .vc_por(vc_por), .hot(hot),
  .src_en(src_en), .sw_en(sw_en), .mode(mode), .rst_cnt(rst_cnt)
);

// File: tb/restart_seq_bench.sv
`timescale 1ns/1ps
module restart_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vc_hi = 1'b0, vc_lo = 1'b1, vc_por = 1'b0, hot = 1'b0;
  logic src_en, sw_en;
  logic [1:0] mode;
  logic [2:0] rst_cnt;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  restart_seq #(.CNT_W(3)) u_restart_seq (
    .clk(clk), .rst_n(rst_n), .vc_hi(vc_hi), .vc_lo(vc_lo), .vc_por(vc_por),
    .hot(hot), .src_en(src_en), .sw_en(sw_en), .mode(mode), .rst_cnt(rst_cnt)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_out(string req, int m, int s, int w, int c);
    n_chk++;
    if (mode !== m || src_en !== s || sw_en !== w || rst_cnt !== c) begin
      n_bad++;
      $display("FAIL %s: got mode=%0d src=%0d sw=%0d cnt=%0d, want mode=%0d src=%0d sw=%0d cnt=%0d",
               req, mode, src_en, sw_en, rst_cnt, m, s, w, c);
    end
  endtask

  task automatic charge_to_hi();
    vc_lo = 1'b0; vc_hi = 1'b1; tick();
  endtask

  task automatic drop_to_lo();
    vc_hi = 1'b0; vc_lo = 1'b1; tick();
  endtask

  task automatic t_reset();
    expect_out("R1 in reset", 0, 1, 0, 0);
    rst_n = 1'b1; tick();
    expect_out("R1 after release", 0, 1, 0, 0);
    tick();
    expect_out("R1 lo ignored in START", 0, 1, 0, 0);
  endtask

  task automatic t_first_start();
    charge_to_hi();
    expect_out("R2 first upper crossing", 1, 0, 1, 0);
    tick();
    expect_out("R2 stays running", 1, 0, 1, 0);
  endtask

  task automatic t_autorestart();
    drop_to_lo();
    expect_out("R3 sag stops switching", 2, 1, 0, 0);
    charge_to_hi();
    expect_out("R5 first completion", 2, 0, 0, 1);
    for (int k = 2; k <= 7; k++) begin
      drop_to_lo();
      expect_out("R4 source on at lower", 2, 1, 0, k - 1);
      charge_to_hi();
      expect_out("R5 completion count", 2, 0, 0, k);
    end
    drop_to_lo();
    charge_to_hi();
    expect_out("R6 eighth cycle restarts", 1, 0, 1, 0);
  endtask

  task automatic t_thermal();
    hot = 1'b1; tick(); hot = 1'b0;
    expect_out("R7 hot latches off", 3, 0, 0, 0);
    for (int k = 0; k < 10; k++) begin
      drop_to_lo();
      expect_out("R4 latched source on", 3, 1, 0, 0);
      charge_to_hi();
      expect_out("R7 latched no count", 3, 0, 0, 0);
    end
    vc_por = 1'b1; vc_hi = 1'b0; vc_lo = 1'b1; tick(); vc_por = 1'b0;
    expect_out("R8 por clears latch", 0, 1, 0, 0);
    charge_to_hi();
    expect_out("R8 immediate start", 1, 0, 1, 0);
  endtask

  task automatic t_collide();
    drop_to_lo();
    charge_to_hi();
    for (int k = 2; k <= 7; k++) begin
      drop_to_lo();
      charge_to_hi();
    end
    expect_out("R5 seven done", 2, 0, 0, 7);
    drop_to_lo();
    vc_lo = 1'b0; vc_hi = 1'b1; hot = 1'b1; tick(); hot = 1'b0;
    expect_out("R10 hot beats restart", 3, 0, 0, 0);
    drop_to_lo();
    vc_por = 1'b1; hot = 1'b1; tick(); vc_por = 1'b0; hot = 1'b0;
    expect_out("R8 por beats hot", 0, 1, 0, 0);
    charge_to_hi();
    expect_out("R8 restart after por", 1, 0, 1, 0);
  endtask

  initial begin
    #1;
    tick();
    t_reset();
    t_first_start();
    t_autorestart();
    t_thermal();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule